// File: doc/BRIEF.md
# Two-Wire Target for Synthesizer Divider and Control Words

This block is a two-wire (I2C) target that sits in front of a frequency synthesizer. A host writes 15-bit divider and control words to it and reads back an 8-bit status byte. The block samples SCL and SDA through a two-flop synchronizer on the core clock. It pulls SDA low through an open-drain enable, and it acknowledges its own address and every write data byte.

In a write, data bytes arrive in pairs. The top bit of the first byte in each pair decides which register the pair loads. A register and its one-cycle load strobe update only after the second byte of the pair arrives. In a read, the block sends the status byte repeatedly, sampling the status input again at the start of each byte, for as long as the host acknowledges.

Top module: `pll_i2c_target`

## Requirements
- R1: After reset, the divider and control outputs are zero, both load strobes are low and the SDA pull-down enable is low.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged: SDA is held low during the ninth clock. A mismatch is not acknowledged, and SDA stays released for the rest of the transfer until the next start.
- R3: In a write, a pair whose first byte has bit 7 equal to 0 sets div_o to {first[6:0], second[7:0]} and pulses div_load_o for one clock.
- R4: A pair whose first byte has bit 7 equal to 1 sets ctrl_o to {first[6:0], second[7:0]} and pulses ctrl_load_o for one clock. Pairs of either type may follow one another in a single transfer.
- R5: Every data byte of an addressed write is acknowledged on its ninth clock.
- R6: Each pair loads exactly one register. A stop that follows an odd number of data bytes discards the unpaired byte, and no register changes.
- R7: In a read (R/W bit 1), the status byte is shifted out MSB first. status_i is sampled at the start of each byte. Another byte follows each host acknowledge. After a host non-acknowledge, SDA stays released.
- R8: A repeated start discards any unpaired byte and restarts address reception.
- R9: div_o and ctrl_o change only in the cycle their load strobe is high, and each strobe lasts a single clock per pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved wired-AND value) |
| sda_oe_o | output | 1 | High pulls SDA low |
| status_i | input | 8 | Status byte returned on reads |
| div_o | output | 15 | Divider word |
| div_load_o | output | 1 | One-cycle strobe when div_o is loaded |
| ctrl_o | output | 15 | Control word |
| ctrl_load_o | output | 1 | One-cycle strobe when ctrl_o is loaded |

## Verification
The hardest state to reach is a pending half-pair that is cut off by a stop or a repeated start. The test must then show that the stray byte neither loads a register nor shifts the pairing of the bytes that follow. The bench sends a single data byte with its top bit set and ends the transfer, or restarts it, right after that byte. It then writes a fresh divider pair and checks that only div_o moved, with the value built from the new pair alone. Reads change status_i in the middle of each byte, which shows that the value is sampled at each byte boundary.

// File: rtl/pll_i2c_pkg.sv
package pll_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[MSB-1:0], scl_i};
      sda_ff <= {sda_ff[MSB-1:0], sda_i};
      scl_d  <= scl_ff[MSB];
      sda_d  <= sda_ff[MSB];
    end
  end

  assign scl_s      = scl_ff[MSB];
  assign sda_s      = sda_ff[MSB];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import pll_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h61
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              pair_clr_o,
  output bus_st_e           st_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx, tx;
  logic              oe, rw, mack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      rx   <= '0;
      tx   <= '0;
      oe   <= 1'b0;
      rw   <= 1'b0;
      mack <= 1'b0;
    end else if (stop_i) begin
      st <= ST_IDLE;
      oe <= 1'b0;
    end else if (start_i) begin
      st  <= ST_ADDR;
      cnt <= '0;
      oe  <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WDATA: begin
          if (rise_i) begin
            rx  <= {rx[BYTE_W-2:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (fall_i && cnt == FULL) begin
            cnt <= '0;
            if (st == ST_WDATA) begin
              st <= ST_WACK;
              oe <= 1'b1;
            end else if (rx[BYTE_W-1:1] == DEV_ADDR) begin
              st <= ST_AACK;
              oe <= 1'b1;
              rw <= rx[0];
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        ST_AACK: if (fall_i) begin
          if (rw) begin
            st <= ST_RDATA;
            tx <= status_i;
            oe <= ~status_i[BYTE_W-1];
          end else begin
            st <= ST_WDATA;
            oe <= 1'b0;
          end
        end
        ST_WACK: if (fall_i) begin
          st <= ST_WDATA;
          oe <= 1'b0;
        end
        ST_RDATA: begin
          if (rise_i) cnt <= cnt + 1'b1;
          else if (fall_i) begin
            if (cnt == FULL) begin
              st  <= ST_RACK;
              oe  <= 1'b0;
              cnt <= '0;
            end else begin
              tx <= {tx[BYTE_W-2:0], 1'b0};
              oe <= ~tx[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (rise_i) mack <= ~sda_i;
          else if (fall_i) begin
            if (mack) begin
              st <= ST_RDATA;
              tx <= status_i;
              oe <= ~status_i[BYTE_W-1];
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o   = oe;
  assign byte_stb_o = (st == ST_WDATA) && rise_i && (cnt == LAST);
  assign byte_o     = {rx[BYTE_W-2:0], sda_i};
  assign pair_clr_o = start_i | stop_i;
  assign st_o       = st;
endmodule

// File: rtl/word_pair_sorter.sv
module word_pair_sorter
  import pll_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] div_o,
  output logic              div_load_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              ctrl_load_o
);
  logic [BYTE_W-1:0] first;
  logic              have;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first       <= '0;
      have        <= 1'b0;
      div_o       <= '0;
      ctrl_o      <= '0;
      div_load_o  <= 1'b0;
      ctrl_load_o <= 1'b0;
    end else begin
      div_load_o  <= 1'b0;
      ctrl_load_o <= 1'b0;
      if (clr_i) begin
        have <= 1'b0;
      end else if (stb_i) begin
        if (!have) begin
          first <= byte_i;
          have  <= 1'b1;
        end else begin
          have <= 1'b0;
          if (first[BYTE_W-1]) begin
            ctrl_o      <= {first[BYTE_W-2:0], byte_i};
            ctrl_load_o <= 1'b1;
          end else begin
            div_o      <= {first[BYTE_W-2:0], byte_i};
            div_load_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pll_i2c_target.sv
module pll_i2c_target
  import pll_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h61,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] status_i,
  output logic [WORD_W-1:0] div_o,
  output logic              div_load_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              ctrl_load_o
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic byte_stb, pair_clr;
  logic [BYTE_W-1:0] rx_byte;
  bus_st_e st;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  i2c_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .rise_i(scl_rise), .fall_i(scl_fall),
    .start_i(bus_start), .stop_i(bus_stop), .status_i,
    .sda_oe_o, .byte_stb_o(byte_stb), .byte_o(rx_byte),
    .pair_clr_o(pair_clr), .st_o(st)
  );

  word_pair_sorter u_sort (
    .clk_i, .rst_ni, .clr_i(pair_clr), .stb_i(byte_stb), .byte_i(rx_byte),
    .div_o, .div_load_o, .ctrl_o, .ctrl_load_o
  );
endmodule

// File: rtl/pll_i2c_checker.sv
module pll_i2c_checker
  import pll_i2c_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_fall,
  input bus_st_e           st,
  input logic              sda_oe_o,
  input logic [WORD_W-1:0] div_o,
  input logic              div_load_o,
  input logic [WORD_W-1:0] ctrl_o,
  input logic              ctrl_load_o
);
  assert_single_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(div_load_o && ctrl_load_o));

  assert_div_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> div_load_o);

  assert_ctrl_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> ctrl_load_o);

  assert_drive_after_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  assert_skip_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SKIP || st == ST_IDLE) |-> !sda_oe_o);
endmodule

bind pll_i2c_target pll_i2c_checker u_chk (
  .clk_i, .rst_ni, .scl_fall, .st, .sda_oe_o,
  .div_o, .div_load_o, .ctrl_o, .ctrl_load_o
);

// File: tb/pll_i2c_target_bench.sv
`timescale 1ns/1ps
module pll_i2c_target_bench;
  localparam logic [6:0] ADDR = 7'h61;
  localparam int Q = 8;
  localparam int H = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] status;
  logic [14:0] div_w, ctrl_w;
  logic div_ld, ctrl_ld;
  wire  bus_sda = sda_m & ~sda_oe;

  int checks = 0, fails = 0, div_loads = 0, ctrl_loads = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pll_i2c_target #(.DEV_ADDR(ADDR)) u_pll_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .sda_oe_o(sda_oe), .status_i(status),
    .div_o(div_w), .div_load_o(div_ld), .ctrl_o(ctrl_w), .ctrl_load_o(ctrl_ld)
  );

  always @(negedge clk) begin
    if (div_ld)  div_loads++;
    if (ctrl_ld) ctrl_loads++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wc(H); scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b0; wc(Q); scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b1; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wc(Q); scl_m = 1'b1; wc(H); scl_m = 1'b0; wc(Q);
    end
    sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(H/2);
    ack = ~bus_sda;
    wc(H/2); scl_m = 1'b0; wc(Q);
  endtask

  task automatic read_byte(input logic host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wc(Q); scl_m = 1'b1; wc(H/2); d[i] = bus_sda; wc(H/2); scl_m = 1'b0;
    end
    wc(Q);
    sda_m = ~host_ack; wc(Q); scl_m = 1'b1; wc(H); scl_m = 1'b0; wc(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] hi_b(input int i, input logic typ);
    return {typ, 7'((i * 37 + 3) & 7'h7f)};
  endfunction
  function automatic logic [7:0] lo_b(input int i);
    return 8'((i * 91 + 5) & 8'hff);
  endfunction
  function automatic logic [7:0] st_v(input int k);
    return 8'((k * 73 + 166) & 8'hff);
  endfunction

  initial begin
    logic ack;
    logic [7:0] rd;
    int d0, c0;
    logic [14:0] exp_div, exp_ctrl;
    status = 8'h00;
    wc(3); rst_n = 1'b1; wc(3);
    chk("R1 div reset", 32'(div_w), 0);
    chk("R1 ctrl reset", 32'(ctrl_w), 0);
    chk("R1 oe reset", 32'(sda_oe), 0);

    // R2: sweep single-bit address mismatches
    for (int k = 0; k < 7; k++) begin
      bus_start();
      send_byte({ADDR ^ 7'(1 << k), 1'b0}, ack);
      chk("R2 mismatch nack", 32'(ack), 0);
      send_byte(8'h00, ack);
      chk("R2 no ack after mismatch", 32'(ack), 0);
      send_byte(8'h12, ack);
      bus_stop();
      chk("R2 no load after mismatch", 32'(div_loads + ctrl_loads), 0);
    end

    // R3/R5/R9: divider pairs, one transfer each
    exp_div = '0; exp_ctrl = '0;
    for (int i = 0; i < 12; i++) begin
      d0 = div_loads;
      bus_start();
      send_byte({ADDR, 1'b0}, ack);
      chk("R2 address ack", 32'(ack), 1);
      send_byte(hi_b(i, 1'b0), ack);
      chk("R5 first byte ack", 32'(ack), 1);
      send_byte(lo_b(i), ack);
      chk("R5 second byte ack", 32'(ack), 1);
      bus_stop();
      exp_div = {hi_b(i, 1'b0)[6:0], lo_b(i)};
      chk("R3 div value", 32'(div_w), 32'(exp_div));
      chk("R9 single strobe", 32'(div_loads - d0), 1);
      chk("R6 ctrl untouched", 32'(ctrl_w), 32'(exp_ctrl));
    end

    // R4: alternating ctrl/div pairs inside one transfer
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    for (int i = 20; i < 28; i++) begin
      logic typ;
      typ = (i % 2 == 0);
      d0 = div_loads; c0 = ctrl_loads;
      send_byte(hi_b(i, typ), ack);
      send_byte(lo_b(i), ack);
      wc(2);
      if (typ) begin
        exp_ctrl = {hi_b(i, 1'b1)[6:0], lo_b(i)};
        chk("R4 ctrl value", 32'(ctrl_w), 32'(exp_ctrl));
        chk("R4 ctrl strobe", 32'(ctrl_loads - c0), 1);
        chk("R6 div kept", 32'(div_w), 32'(exp_div));
      end else begin
        exp_div = {hi_b(i, 1'b0)[6:0], lo_b(i)};
        chk("R3 div value mixed", 32'(div_w), 32'(exp_div));
        chk("R6 ctrl kept", 32'(ctrl_w), 32'(exp_ctrl));
      end
    end
    bus_stop();

    // R6: odd byte then stop is discarded
    d0 = div_loads; c0 = ctrl_loads;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'hff, ack);
    bus_stop();
    chk("R6 odd byte no load", 32'(div_loads + ctrl_loads - d0 - c0), 0);
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h2a, ack);
    send_byte(8'h5c, ack);
    bus_stop();
    chk("R6 pairing restarts", 32'(div_w), 32'({7'h2a, 8'h5c}));
    chk("R6 ctrl after odd", 32'(ctrl_w), 32'(exp_ctrl));

    // R8: repeated start after odd byte
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'hc3, ack);
    bus_rstart();
    send_byte({ADDR, 1'b0}, ack);
    chk("R8 address ack after rstart", 32'(ack), 1);
    send_byte(8'h11, ack);
    send_byte(8'h99, ack);
    bus_stop();
    chk("R8 div after rstart", 32'(div_w), 32'({7'h11, 8'h99}));
    chk("R8 ctrl unchanged", 32'(ctrl_w), 32'(exp_ctrl));

    // R7: streamed status reads, status changed mid-byte
    status = st_v(0);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk("R7 read address ack", 32'(ack), 1);
    for (int k = 0; k < 5; k++) begin
      status = st_v(k + 1);
      read_byte(k < 4, rd);
      chk("R7 status byte", 32'(rd), 32'(st_v(k)));
    end
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (sda_oe) begin chk("R7 released after nack", 32'(sda_oe), 0); break; end
    end
    scl_m = 1'b1; wc(H/2);
    chk("R7 line high after nack", 32'(bus_sda), 1);
    scl_m = 1'b0; wc(Q);
    bus_stop();

    // R8: write then repeated start into read
    status = 8'h5a;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    bus_rstart();
    send_byte({ADDR, 1'b1}, ack);
    read_byte(1'b0, rd);
    chk("R8 read after rstart", 32'(rd), 32'h5a);
    bus_stop();
    chk("R1 idle release", 32'(sda_oe), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule